// File: doc/BRIEF.md
# Ring Oscillator Race Evaluator

This block turns a bank of free-running ring-oscillator clocks into a 4-bit device fingerprint. An 8-bit challenge picks two oscillators. Each picked oscillator clocks its own counter, and the two counters race toward a terminal count. The response bit records which one reaches that count first. Four independent slices do this at once, and each slice owns its own bank of sixteen oscillators. Small frequency differences between nominally equal oscillators decide every bit.

The system clock domain runs a short sequence on each evaluation. A start pulse latches the challenge and drops the arm level. A flush period follows, so that every counter clears in its own oscillator domain. Then arm is raised and all counters start together. Each slice decides as soon as a synchronized finish flag arrives. The block raises done once all four slices have decided.

Challenge and start are plain control pins. They have no valid/ready handshake and no back-pressure. A start pulse that arrives while an evaluation is running is dropped.

Top module: `ro_race_puf`

## Requirements
- R1: After reset, `response` is 0 and `done` is 0.
- R2: For slice s, `challenge[7:4]` selects oscillator A and `challenge[3:0]` selects oscillator B. Each oscillator's counter counts from 0 to TERM (default 255). `response[s]` is 1 when A's counter reaches TERM first, and 0 when B's does.
- R3: Bus `osc_clk[s*16 + i]` is oscillator i of slice s. The slices evaluate independently, and slice s drives `response[s]`.
- R4: When both nibbles of the challenge select the same oscillator, every slice gives 0.
- R5: When both finish flags of a slice reach the system domain in the same system-clock cycle, that slice gives 0.
- R6: The cycle after an accepted start pulse, `done` is 0 and `response` is 0. `done` rises with the new response once every slice has decided. Both then hold until the next accepted start.
- R7: A start pulse is accepted only while the block is idle. A pulse during an evaluation has no effect on the result.
- R8: The challenge is captured at the accepted start. Changing `challenge` afterwards changes neither the running evaluation nor a held response.
- R9: Each evaluation clears both counters of every slice before they are enabled again. Repeated and alternating challenges therefore give the same per-challenge result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| challenge | input | 8 | Upper nibble selects oscillator A, lower nibble selects oscillator B |
| start | input | 1 | One-cycle pulse that begins an evaluation |
| osc_clk | input | 64 | Oscillator clocks, 16 per slice, slice-major |
| response | output | 4 | One race result per slice |
| done | output | 1 | Response valid, held until the next accepted start |

## Verification
The hardest case to reach from the ports is a true tie, where both finish flags cross into the system domain in the same cycle. Free-running oscillators with distinct periods never produce one. To force it, the bench switches every oscillator input to one shared clock while the block is idle, so both counters of each slice step on identical edges. The normal table uses a fixed period permutation for each slice, with at least 127 ns of race spread, so the expected winners follow from the periods alone.

// File: rtl/puf_pkg.sv
package puf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FLUSH = 2'd1,
    ST_RACE  = 2'd2
  } eval_state_e;
endpackage

// File: rtl/puf_sync2.sv
module puf_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/puf_race_counter.sv
module puf_race_counter #(
  parameter int TERM  = 255,
  parameter int CNT_W = 8
) (
  input  logic osc_clk,
  input  logic rst_n,
  input  logic arm,
  output logic fin
);
  logic             arm_s;
  logic [CNT_W-1:0] cnt;

  puf_sync2 u_arm_sync (.clk(osc_clk), .rst_n(rst_n), .d(arm), .q(arm_s));

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      fin <= 1'b0;
    end else if (!arm_s) begin
      cnt <= '0;
      fin <= 1'b0;
    end else if (!fin) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(TERM - 1)) fin <= 1'b1;
    end
  end

  // R2: the counter never passes the terminal count
  p_count_limit_r2: assert property (@(posedge osc_clk) disable iff (!rst_n)
    cnt <= CNT_W'(TERM));
  // R2: a raised finish flag means the terminal count was reached
  p_fin_at_term_r2: assert property (@(posedge osc_clk) disable iff (!rst_n)
    fin |-> cnt == CNT_W'(TERM));
  // R9: a disarmed counter is cleared on the next oscillator edge
  p_disarm_clears_r9: assert property (@(posedge osc_clk) disable iff (!rst_n)
    !arm_s |=> cnt == '0 && !fin);
endmodule

// File: rtl/puf_race_slice.sv
module puf_race_slice #(
  parameter int N_OSC = 16,
  parameter int TERM  = 255,
  parameter int SEL_W = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_OSC-1:0] osc_bank,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_b,
  input  logic             arm,
  input  logic             eval,
  output logic             quiet,
  output logic             decided,
  output logic             bit_o
);
  logic [1:0]       race_clk;
  logic [1:0]       fin_raw;
  logic [1:0]       fin_s;
  logic [SEL_W-1:0] sel [2];
  logic             same;

  assign sel[0] = sel_a;
  assign sel[1] = sel_b;
  assign same   = (sel_a == sel_b);
  assign quiet  = ~|fin_s;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign race_clk[g] = osc_bank[sel[g]];
    puf_race_counter #(.TERM(TERM), .CNT_W(CNT_W)) u_cnt (
      .osc_clk(race_clk[g]), .rst_n(rst_n), .arm(arm), .fin(fin_raw[g])
    );
    puf_sync2 u_fin_sync (.clk(clk), .rst_n(rst_n), .d(fin_raw[g]), .q(fin_s[g]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      decided <= 1'b0;
      bit_o   <= 1'b0;
    end else if (!eval) begin
      decided <= 1'b0;
      bit_o   <= 1'b0;
    end else if (!decided) begin
      if (same || fin_s[1]) begin
        decided <= 1'b1;
        bit_o   <= 1'b0;
      end else if (fin_s[0]) begin
        decided <= 1'b1;
        bit_o   <= 1'b1;
      end
    end
  end

  // R4: one oscillator on both lanes always decides 0
  p_same_sel_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (decided && same) |-> !bit_o);
  // R5: simultaneous synchronized finishes resolve to 0
  p_tie_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !decided && fin_s[0] && fin_s[1]) |=> (decided && !bit_o));
  // R6: a decision is not revised during the same evaluation
  p_decision_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && decided) |=> (!eval || (decided && $stable(bit_o))));
endmodule

// File: rtl/ro_race_puf.sv
module ro_race_puf #(
  parameter int N_OSC        = 16,
  parameter int N_SLICE      = 4,
  parameter int TERM         = 255,
  parameter int FLUSH_CYCLES = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [2*$clog2(N_OSC)-1:0]       challenge,
  input  logic                             start,
  input  logic [N_SLICE*N_OSC-1:0]         osc_clk,
  output logic [N_SLICE-1:0]               response,
  output logic                             done
);
  import puf_pkg::*;

  localparam int SEL_W  = $clog2(N_OSC);
  localparam int CHAL_W = 2 * SEL_W;
  localparam int CNT_W  = $clog2(TERM + 1);
  localparam int FL_W   = $clog2(FLUSH_CYCLES + 1);

  eval_state_e         state;
  logic [CHAL_W-1:0]   chal_q;
  logic [FL_W-1:0]     flush_cnt;
  logic                arm;
  logic                eval;
  logic [N_SLICE-1:0]  quiet;
  logic [N_SLICE-1:0]  decided;
  logic [N_SLICE-1:0]  bits;

  assign eval = (state == ST_RACE);

  for (genvar s = 0; s < N_SLICE; s++) begin : g_slice
    puf_race_slice #(.N_OSC(N_OSC), .TERM(TERM), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_slice (
      .clk(clk), .rst_n(rst_n),
      .osc_bank(osc_clk[s*N_OSC +: N_OSC]),
      .sel_a(chal_q[CHAL_W-1:SEL_W]), .sel_b(chal_q[SEL_W-1:0]),
      .arm(arm), .eval(eval),
      .quiet(quiet[s]), .decided(decided[s]), .bit_o(bits[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      chal_q    <= '0;
      flush_cnt <= '0;
      arm       <= 1'b0;
      response  <= '0;
      done      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          chal_q    <= challenge;
          flush_cnt <= '0;
          arm       <= 1'b0;
          response  <= '0;
          done      <= 1'b0;
          state     <= ST_FLUSH;
        end
        ST_FLUSH: begin
          if (flush_cnt != FL_W'(FLUSH_CYCLES)) flush_cnt <= flush_cnt + 1'b1;
          else if (&quiet) begin
            arm   <= 1'b1;
            state <= ST_RACE;
          end
        end
        ST_RACE: if (&decided) begin
          response <= bits;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: an accepted start withdraws the previous result
  p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == ST_IDLE) |=> (!done && response == '0));
  // R6: the result holds until a new start
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(response)));
  // R6: done only rises once every slice has decided
  p_done_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(&decided));
  // R7, R8: a busy block keeps its captured challenge
  p_busy_keeps_chal_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(chal_q));
  // R9: counters are only armed after the flush found all finish flags low
  p_arm_after_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arm) |-> $past(&quiet));
endmodule

// File: tb/ro_race_puf_tb.sv
`timescale 1ns/1ps
module ro_race_puf_tb;
  localparam int NS = 4;
  localparam int NO = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    challenge = '0;
  logic          start = 1'b0;
  logic [63:0]   osc_free;
  logic [63:0]   osc_clk;
  logic          common_clk = 1'b0;
  logic          tie_mode = 1'b0;
  logic [3:0]    response;
  logic          done;
  int            total = 0;
  int            bad = 0;

  always #2.5 clk = ~clk;
  always #3.5 common_clk = ~common_clk;

  // slice s oscillator i: rank (7i+3s) mod 16, period 6 ns + 0.5 ns * rank
  for (genvar k = 0; k < NS*NO; k++) begin : g_osc
    localparam int  RANK = (7*(k % NO) + 3*(k / NO)) % NO;
    localparam real HALF = (6.0 + 0.5*RANK) / 2.0;
    initial osc_free[k] = 1'b0;
    always #(HALF) osc_free[k] = ~osc_free[k];
    assign osc_clk[k] = tie_mode ? common_clk : osc_free[k];
  end

  ro_race_puf u_dut (
    .clk(clk), .rst_n(rst_n), .challenge(challenge), .start(start),
    .osc_clk(osc_clk), .response(response), .done(done)
  );

  typedef struct packed { logic [7:0] chal; logic [3:0] exp; } vec_t;
  localparam vec_t VECS [9] = '{
    '{8'h12, 4'b1001}, '{8'h21, 4'b0110}, '{8'h07, 4'b1111},
    '{8'h70, 4'b0000}, '{8'h9C, 4'b1110}, '{8'hB6, 4'b0010},
    '{8'h4F, 4'b0100}, '{8'h8D, 4'b1011}, '{8'h55, 4'b0000}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [7:0] c);
    @(negedge clk);
    challenge = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_vec(input logic [7:0] c, input logic [3:0] exp, input string req);
    bit ok;
    pulse_start(c);
    check("R6 done cleared", {7'd0, done}, 8'd0);
    check("R6 response cleared", {4'd0, response}, 8'd0);
    wait_done(ok);
    check({req, " done reached"}, {7'd0, ok}, 8'd1);
    check(req, {4'd0, response}, {4'd0, exp});
  endtask

  initial begin
    #(200000 * 5.0);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ok;
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 response", {4'd0, response}, 8'd0);
    check("R1 done", {7'd0, done}, 8'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", {3'd0, done, response}, 8'd0);

    // R2, R3, R4: table of vectors
    foreach (VECS[i]) run_vec(VECS[i].chal, VECS[i].exp, "R2/R3 race table");

    // R9: repeat and alternate
    run_vec(8'h12, 4'b1001, "R9 repeat");
    run_vec(8'h12, 4'b1001, "R9 repeat again");
    run_vec(8'h21, 4'b0110, "R9 alternate");

    // R4: each same-oscillator selection
    run_vec(8'h00, 4'b0000, "R4 same osc 0");
    run_vec(8'hFF, 4'b0000, "R4 same osc 15");

    // R7, R8: start during evaluation and challenge change are ignored
    pulse_start(8'h12);
    challenge = 8'h21;
    repeat (30) @(negedge clk);
    pulse_start(8'h21);
    wait_done(ok);
    check("R7 done reached", {7'd0, ok}, 8'd1);
    check("R7 busy start ignored", {4'd0, response}, 8'h09);

    // R6, R8: held result ignores idle challenge changes
    challenge = 8'h70;
    repeat (200) @(negedge clk);
    check("R6 done held", {7'd0, done}, 8'd1);
    check("R8 response held", {4'd0, response}, 8'h09);

    // R5: forced tie, all oscillators on one clock
    tie_mode = 1'b1;
    run_vec(8'h12, 4'b0000, "R5 tie");
    run_vec(8'h07, 4'b0000, "R5 tie other pair");
    tie_mode = 1'b0;
    run_vec(8'h8D, 4'b1011, "R9 after tie");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule